// File: doc/BRIEF.md
# Dual-Read Register File with Constants

This block is the architectural register store of a small datapath. It holds sixteen words of sixteen bits. One port writes on the rising clock edge. Two read ports return data combinationally, so an operation that reads two operands and writes one result can finish in a single cycle. For example, adding entry 0 to entry 1 into entry 2, and then adding entries 1 and 2 into entry 3, leaves 0x0001 in entry 2 and 0x0002 in entry 3.

Two entries are constants. Index 0 always reads zero and index 1 always reads one, and writes aimed at either index are dropped. An active-low clear input acts at once, without waiting for a clock edge. It empties every writable entry, and the two constants keep their values.

Top module: `rf_dual_read`

## Requirements
- R1: The file holds DEPTH (default 16) entries of DATA_W (default 16) bits each. Entries are addressed by selects of $clog2(DEPTH) bits (default 4).
- R2: When `load` is 1 at a rising `clk` edge, `wr_data` is stored in the entry selected by `wr_addr`, provided that index is 2 or higher.
- R3: When `load` is 0 at a rising `clk` edge, no entry changes.
- R4: `rd_a_data` always shows the entry selected by `rd_a_sel`, and `rd_b_data` always shows the entry selected by `rd_b_sel`. The two ports are independent and neither uses the clock.
- R5: Index 0 always reads 0x0000, and a write addressed to it has no effect.
- R6: Index 1 always reads 0x0001, and a write addressed to it has no effect.
- R7: While `clear_n` is 0, every entry except index 1 reads 0x0000 with no clock edge needed, and index 1 reads 0x0001.
- R8: Clear wins over load. A write attempted while `clear_n` is 0 leaves the entry at zero after clear is released.
- R9: There is no write-through. Reading the entry being written returns the old value until the edge, then the new value.
- R10: When both selects are equal, both read ports return the same data.
- R11: Using the outputs as operands, 0+1 written to index 2 and then 1+(index 2) written to index 3 leaves index 2 = 0x0001 and index 3 = 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Index of the entry to write |
| wr_data | input | DATA_W | Data to write |
| rd_a_sel | input | ADDR_W | Index read by port A |
| rd_b_sel | input | ADDR_W | Index read by port B |
| rd_a_data | output | DATA_W | Contents of the entry selected by port A |
| rd_b_data | output | DATA_W | Contents of the entry selected by port B |

## Verification
The bench builds the block with its default parameters: sixteen entries of sixteen bits and 4-bit selects. Every index is therefore reachable, including the top one (15) and the two constants, and the stored data can use full-width patterns with the top and bottom bits set. With this configuration the table can sweep both constant indices, the last writable index, equal selects on the two ports, and reads of an entry in the same cycle it is written. Clear is then driven between clock edges to show that it acts without a clock.

// File: rtl/rf_pkg.sv
package rf_pkg;

   typedef enum logic [1:0] {
      CELL_STORE = 2'd0,
      CELL_ZERO  = 2'd1,
      CELL_ONE   = 2'd2
   } cell_kind_e;

   // Number of low indices that hold constants instead of storage.
   localparam int CONST_CELLS = 2;

   function automatic cell_kind_e kind_of(input int idx);
      if (idx == 0)      return CELL_ZERO;
      else if (idx == 1) return CELL_ONE;
      else               return CELL_STORE;
   endfunction

endpackage

// File: rtl/rf_word.sv
module rf_word #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              clear_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n)  q <= '0;
      else if (we)   q <= d;
   end

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4,
   parameter int FIRST  = 2
) (
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   output logic [DEPTH-1:FIRST] we
);

   for (genvar i = FIRST; i < DEPTH; i++) begin : g_dec
      assign we[i] = load && (addr == ADDR_W'(i));
   end

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic [DEPTH*DATA_W-1:0] words,
   input  logic [ADDR_W-1:0]       sel,
   output logic [DATA_W-1:0]       data
);

   always_comb begin
      data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sel == ADDR_W'(i)) data = words[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read #(
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              clear_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_a_sel,
   input  logic [ADDR_W-1:0] rd_b_sel,
   output logic [DATA_W-1:0] rd_a_data,
   output logic [DATA_W-1:0] rd_b_data
);
   import rf_pkg::*;

   localparam int FIRST = CONST_CELLS;
   localparam int FLAT_W = DEPTH * DATA_W;

   if (DEPTH <= FIRST) begin : g_bad_depth
      $error("rf_dual_read: DEPTH must exceed the constant entries");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rf_dual_read: DATA_W must be at least 1");
   end

   logic [DEPTH-1:FIRST] we;
   logic [FLAT_W-1:0]    words;

   rf_wr_decode #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .FIRST  (FIRST)
   ) u_dec (
      .load (load),
      .addr (wr_addr),
      .we   (we)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam cell_kind_e KIND = kind_of(i);
      if (KIND == CELL_STORE) begin : g_store
         rf_word #(.DATA_W(DATA_W)) u_word (
            .clk     (clk),
            .clear_n (clear_n),
            .we      (we[i]),
            .d       (wr_data),
            .q       (words[i*DATA_W +: DATA_W])
         );
      end else if (KIND == CELL_ONE) begin : g_one
         assign words[i*DATA_W +: DATA_W] = DATA_W'(1);
      end else begin : g_zero
         assign words[i*DATA_W +: DATA_W] = '0;
      end
   end

   rf_rd_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_a (
      .words (words),
      .sel   (rd_a_sel),
      .data  (rd_a_data)
   );

   rf_rd_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_b (
      .words (words),
      .sel   (rd_b_sel),
      .data  (rd_b_data)
   );

endmodule

// File: rtl/rf_dual_read_chk.sv
module rf_dual_read_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              clear_n,
   input logic              load,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_a_sel,
   input logic [ADDR_W-1:0] rd_b_sel,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [DATA_W-1:0] rd_b_data
);

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (load && wr_addr > ADDR_W'(1)) |=>
         ((rd_a_sel != $past(wr_addr)) || (rd_a_data == $past(wr_data))));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
      !load |=> ((rd_a_sel != $past(rd_a_sel)) || $stable(rd_a_data)));

   // R5
   zero_a_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rd_a_sel == '0) |-> (rd_a_data == '0));

   // R5
   zero_b_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rd_b_sel == '0) |-> (rd_b_data == '0));

   // R6
   one_a_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rd_a_sel == ADDR_W'(1)) |-> (rd_a_data == DATA_W'(1)));

   // R10
   same_sel_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rd_a_sel == rd_b_sel) |-> (rd_a_data == rd_b_data));

   // R7
   always @(posedge clk) begin
      if (!clear_n) begin
         clear_state_chk: assert (rd_a_data ==
            ((rd_a_sel == ADDR_W'(1)) ? DATA_W'(1) : DATA_W'(0)));
      end
   end

endmodule

bind rf_dual_read rf_dual_read_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .clear_n   (clear_n),
   .load      (load),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_a_sel  (rd_a_sel),
   .rd_b_sel  (rd_b_sel),
   .rd_a_data (rd_a_data),
   .rd_b_data (rd_b_data)
);

// File: tb/test_rf_dual_read.sv
`timescale 1ns/1ps
module test_rf_dual_read;

   localparam int DW = 16;
   localparam int AW = 4;
   localparam int NV = 11;

   logic          clk = 1'b0;
   logic          clear_n = 1'b0;
   logic          load = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_a_sel = '0;
   logic [AW-1:0] rd_b_sel = '0;
   logic [DW-1:0] rd_a_data;
   logic [DW-1:0] rd_b_data;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   rf_dual_read i_rf_dual_read (
      .clk       (clk),
      .clear_n   (clear_n),
      .load      (load),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_a_sel  (rd_a_sel),
      .rd_b_sel  (rd_b_sel),
      .rd_a_data (rd_a_data),
      .rd_b_data (rd_b_data)
   );

   // Row: {load, wr_addr, wr_data, a_sel, b_sel, expect_a, expect_b}
   // Expected values are those read before the row's clock edge.
   localparam logic [60:0] VEC [NV] = '{
      {1'b1, 4'd2,  16'hA5A5, 4'd2,  4'd3,  16'h0000, 16'h0000}, // R9 old value
      {1'b1, 4'd3,  16'h1234, 4'd2,  4'd3,  16'hA5A5, 16'h0000}, // R2
      {1'b0, 4'd2,  16'hFFFF, 4'd2,  4'd3,  16'hA5A5, 16'h1234}, // R3 no load
      {1'b1, 4'd0,  16'hBEEF, 4'd2,  4'd0,  16'hA5A5, 16'h0000}, // R3 R5
      {1'b1, 4'd1,  16'hCAFE, 4'd0,  4'd1,  16'h0000, 16'h0001}, // R5
      {1'b1, 4'd15, 16'h8001, 4'd1,  4'd0,  16'h0001, 16'h0000}, // R6
      {1'b0, 4'd0,  16'h0000, 4'd15, 4'd15, 16'h8001, 16'h8001}, // R10
      {1'b1, 4'd15, 16'h0000, 4'd15, 4'd2,  16'h8001, 16'hA5A5}, // R4
      {1'b0, 4'd0,  16'h0000, 4'd15, 4'd14, 16'h0000, 16'h0000}, // R2
      {1'b1, 4'd14, 16'h7FFF, 4'd14, 4'd14, 16'h0000, 16'h0000}, // R9
      {1'b0, 4'd0,  16'h0000, 4'd14, 4'd13, 16'h7FFF, 16'h0000}  // R2 R4
   };

   task automatic chk(input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic read_pair(input logic [AW-1:0] a, input logic [AW-1:0] b);
      @(negedge clk);
      load     = 1'b0;
      rd_a_sel = a;
      rd_b_sel = b;
      #1;
   endtask

   initial begin
      logic [DW-1:0] sum;
      // reset state, R1 R7
      repeat (3) @(posedge clk);
      @(negedge clk);
      clear_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         read_pair(AW'(i), AW'(i));
         chk("R7 reset contents", rd_a_data, (i == 1) ? 16'h0001 : 16'h0000);
      end

      // vector table, R2 R3 R4 R5 R6 R9 R10
      for (int r = 0; r < NV; r++) begin
         @(negedge clk);
         {load, wr_addr, wr_data, rd_a_sel, rd_b_sel} = VEC[r][60:32];
         #1;
         chk("R4 port A table row", rd_a_data, VEC[r][31:16]);
         chk("R4 port B table row", rd_b_data, VEC[r][15:0]);
      end

      // R11 operand sequence
      read_pair(4'd0, 4'd1);
      sum = rd_a_data + rd_b_data;
      @(negedge clk);
      load = 1'b1; wr_addr = 4'd2; wr_data = sum;
      read_pair(4'd1, 4'd2);
      sum = rd_a_data + rd_b_data;
      @(negedge clk);
      load = 1'b1; wr_addr = 4'd3; wr_data = sum;
      read_pair(4'd2, 4'd3);
      chk("R11 entry 2", rd_a_data, 16'h0001);
      chk("R11 entry 3", rd_b_data, 16'h0002);

      // R7 asynchronous clear, R8 priority over load
      read_pair(4'd3, 4'd1);
      load = 1'b1; wr_addr = 4'd5; wr_data = 16'h5555;
      clear_n = 1'b0;
      #0.5;
      chk("R7 clear without edge", rd_a_data, 16'h0000);
      chk("R7 index 1 kept", rd_b_data, 16'h0001);
      repeat (2) @(posedge clk);
      @(negedge clk);
      clear_n = 1'b1;
      load = 1'b0;
      rd_a_sel = 4'd5;
      rd_b_sel = 4'd1;
      #1;
      chk("R8 write during clear dropped", rd_a_data, 16'h0000);
      chk("R7 index 1 after clear", rd_b_data, 16'h0001);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule